// File: doc/BRIEF.md
# NCO Variable-Frequency Generator

This block is a numerically controlled oscillator clocked by a reference clock. A 16-bit phase accumulator grows by an effective step on every reference cycle. Its most significant bit is the square-wave output. A second output pulses high for exactly one cycle each time that square wave rises.

The wave serves as the direct variable-frequency output. The one-cycle pulse serves as the clock enable of a downstream constant-frequency PWM stage. The output frequency is the step times 2^-16 times the reference frequency.

Software loads the frequency word one byte at a time, through separate high-byte and low-byte write strobes. When the word is at or above 0x8000, the block reads it as negative and uses its 16-bit two's complement as the step. A power-of-two step yields an exact half-high, half-low wave.

Top module: `nco_vfreq_gen`

## Requirements
- R1: A high-byte write loads bits 15:8 of the frequency word and a low-byte write loads bits 7:0. Each write leaves the other byte unchanged. A word written at one clock edge is added to the phase at the next edge.
- R2: When the frequency word is below 0x8000, the step added to the phase equals the word.
- R3: When the frequency word is 0x8000 or above, the step is its 16-bit two's complement. Examples: 0xF000 steps by 0x1000, 0xFFFF steps by 1, and 0x8000 steps by 0x8000, so the wave toggles every cycle.
- R4: The phase accumulator adds the step once per reference cycle, modulo 2^16. The wave output is the accumulator's bit 15. A step of 0x1000 gives one wave period every 16 cycles.
- R5: The tick output is high for exactly one cycle in each cycle where the wave is 1 after being 0 in the previous cycle. It is never high in two adjacent cycles.
- R6: A frequency word of zero freezes the phase. The wave then holds its level and no ticks occur.
- R7: Reset clears the accumulator and the frequency word. After reset the wave and tick are 0, and they stay 0 until a nonzero word is written.
- R8: A power-of-two step gives a wave whose high time equals its low time. For example, step 0x1000 gives 8 cycles high and 8 cycles low.
- R9: Writing a new frequency word does not clear the phase. The accumulator continues from its current value with the new step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_hi | input | 1 | Load the write byte into the upper half of the frequency word |
| wr_lo | input | 1 | Load the write byte into the lower half of the frequency word |
| wr_byte | input | 8 | Byte value to load |
| wave_o | output | 1 | Variable-frequency square wave (accumulator MSB) |
| tick_o | output | 1 | One-cycle pulse on each rising edge of the wave |

## Verification
Some properties are checked by assertions on every cycle:
- a tick only appears while the wave is high, and never in two adjacent cycles;
- a zero step leaves the phase frozen;
- a byte write leaves the other byte untouched;
- the folded step never exceeds 0x8000.

Other behaviours can only be shown by the bench's scenarios:
- the exact period and duty produced by a given word;
- the equivalence of a negative word with its positive two's complement;
- a word change that keeps the running phase;
- the clearing effect of reset.

The bench compares the wave and tick on every cycle against a reference accumulator.

// File: rtl/nco_pkg.sv
package nco_pkg;

   // Byte lanes of the frequency word; the lane index selects the bit slice.
   typedef enum logic [0:0] {
      LANE_LOW  = 1'b0,
      LANE_HIGH = 1'b1
   } nco_lane_e;

   localparam int unsigned NCO_LANES = 2;

endpackage

// File: rtl/nco_cword_reg.sv
module nco_cword_reg #(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned N_LANES = nco_pkg::NCO_LANES,
   localparam int unsigned CW_W   = BYTE_W * N_LANES
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_LANES-1:0]  lane_we,
   input  logic [BYTE_W-1:0]   lane_data,
   output logic [CW_W-1:0]     cword
);

   if (BYTE_W < 1) begin : g_bad_byte
      $error("nco_cword_reg: BYTE_W must be at least 1");
   end
   if (N_LANES < 1) begin : g_bad_lanes
      $error("nco_cword_reg: N_LANES must be at least 1");
   end

   for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
      logic [BYTE_W-1:0] slice_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slice_q <= '0;
         end else if (lane_we[ln]) begin
            slice_q <= lane_data;
         end
      end

      assign cword[ln*BYTE_W +: BYTE_W] = slice_q;

      // A lane that is not written keeps its byte.
      p_lane_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
         !lane_we[ln] |=> $stable(cword[ln*BYTE_W +: BYTE_W]))
         else $error("p_lane_hold_r1: lane %0d changed without a write", ln);
   end

endmodule

// File: rtl/nco_step_map.sv
module nco_step_map #(
   parameter int unsigned CW_W     = 16,
   parameter bit          FOLD_NEG = 1'b1
) (
   input  logic [CW_W-1:0] cword,
   output logic [CW_W-1:0] step
);

   localparam logic [CW_W-1:0] HALF = {1'b1, {(CW_W-1){1'b0}}};

   if (CW_W < 2) begin : g_bad_width
      $error("nco_step_map: CW_W must be at least 2");
   end

   if (FOLD_NEG) begin : g_fold
      // Words in the upper half count as negative; use their magnitude.
      always_comb begin
         if (cword[CW_W-1]) begin
            step = (~cword) + {{(CW_W-1){1'b0}}, 1'b1};
         end else begin
            step = cword;
         end
      end

      always_comb begin
         p_step_range_r3: assert (step <= HALF)
            else $error("p_step_range_r3: folded step %0h above half range", step);
      end
   end else begin : g_plain
      assign step = cword;
   end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int unsigned STEP_W = 16,
   parameter int unsigned ACC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STEP_W-1:0] step,
   output logic              wave,
   output logic              tick
);

   localparam int unsigned PAD_W = ACC_W - STEP_W;

   if (ACC_W < STEP_W) begin : g_bad_acc
      $error("nco_phase_acc: ACC_W must not be below STEP_W");
   end

   logic [ACC_W-1:0] phase_q;
   logic [ACC_W-1:0] step_ext;
   logic             msb_q;

   if (PAD_W == 0) begin : g_same
      assign step_ext = step;
   end else begin : g_pad
      assign step_ext = {{PAD_W{1'b0}}, step};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         msb_q   <= 1'b0;
      end else begin
         phase_q <= phase_q + step_ext;
         msb_q   <= phase_q[ACC_W-1];
      end
   end

   assign wave = phase_q[ACC_W-1];
   assign tick = wave & ~msb_q;

   p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step == '0) |=> $stable(phase_q))
      else $error("p_freeze_r6: phase moved with zero step");

   p_tick_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> wave)
      else $error("p_tick_high_r5: tick while wave low");

   p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick)
      else $error("p_tick_single_r5: tick lasted two cycles");

   p_reset_clear_r7: assert property (@(posedge clk)
      !rst_n |-> (phase_q == '0) && !tick)
      else $error("p_reset_clear_r7: state not cleared in reset");

endmodule

// File: rtl/nco_vfreq_gen.sv
module nco_vfreq_gen #(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned ACC_W    = 2 * BYTE_W,
   parameter bit          FOLD_NEG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [BYTE_W-1:0] wr_byte,
   output logic              wave_o,
   output logic              tick_o
);

   import nco_pkg::*;

   localparam int unsigned CW_W = BYTE_W * NCO_LANES;

   logic [NCO_LANES-1:0] lane_we;
   logic [CW_W-1:0]      cword;
   logic [CW_W-1:0]      step;

   always_comb begin
      lane_we           = '0;
      lane_we[LANE_LOW]  = wr_lo;
      lane_we[LANE_HIGH] = wr_hi;
   end

   nco_cword_reg #(
      .BYTE_W  (BYTE_W),
      .N_LANES (NCO_LANES)
   ) u_cword (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane_we   (lane_we),
      .lane_data (wr_byte),
      .cword     (cword)
   );

   nco_step_map #(
      .CW_W     (CW_W),
      .FOLD_NEG (FOLD_NEG)
   ) u_map (
      .cword (cword),
      .step  (step)
   );

   nco_phase_acc #(
      .STEP_W (CW_W),
      .ACC_W  (ACC_W)
   ) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .wave  (wave_o),
      .tick  (tick_o)
   );

endmodule

// File: tb/sim_nco_vfreq_gen.sv
module sim_nco_vfreq_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_hi = 1'b0;
   logic       wr_lo = 1'b0;
   logic [7:0] wr_byte = 8'h00;
   logic       wave_o;
   logic       tick_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // Reference state built from the requirements.
   logic [15:0] m_cw = 16'h0000;
   logic [15:0] m_acc = 16'h0000;
   logic        m_tick = 1'b0;

   always #4 clk = ~clk;

   nco_vfreq_gen u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi   (wr_hi),
      .wr_lo   (wr_lo),
      .wr_byte (wr_byte),
      .wave_o  (wave_o),
      .tick_o  (tick_o)
   );

   localparam int NV = 8;
   localparam logic [15:0] VEC_CW [NV] = '{16'h4000, 16'h8000, 16'hC000, 16'h0300,
                                            16'hFFFF, 16'h1234, 16'hA5A5, 16'h0000};
   localparam int VEC_N [NV] = '{24, 12, 24, 400, 40, 120, 120, 30};

   function automatic logic [15:0] eff_step(input logic [15:0] w);
      return w[15] ? (16'h0000 - w) : w;   // R2, R3
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // One reference cycle: drive at negedge, update model after the edge, compare at next negedge.
   task automatic cyc(input bit hw, input bit lw, input logic [7:0] b);
      logic old_msb;
      wr_hi = hw; wr_lo = lw; wr_byte = b;
      @(posedge clk);
      old_msb = m_acc[15];
      m_acc   = m_acc + eff_step(m_cw);
      m_tick  = m_acc[15] & ~old_msb;
      if (hw) m_cw[15:8] = b;
      if (lw) m_cw[7:0]  = b;
      @(negedge clk);
      wr_hi = 1'b0; wr_lo = 1'b0;
      check(wave_o == m_acc[15], "R4 wave", wave_o, m_acc[15]);
      check(tick_o == m_tick, "R5 tick", tick_o, m_tick);
   endtask

   task automatic put_word(input logic [15:0] w);
      cyc(1'b1, 1'b0, w[15:8]);
      cyc(1'b0, 1'b1, w[7:0]);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      m_acc = '0; m_cw = '0; m_tick = 1'b0;
      @(negedge clk);
      check(wave_o == 1'b0, "R7 wave in reset", wave_o, 0);
      check(tick_o == 1'b0, "R7 tick in reset", tick_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(wave_o == 1'b0, "R7 wave after reset", wave_o, 0);
   endtask

   // Measures the period between two ticks and the high time in it.
   task automatic measure(input string req, input int exp_per, input int exp_hi);
      int per = 0;
      int hi = 0;
      int guard = 0;
      while (!tick_o && guard < 1000) begin cyc(0, 0, 8'h00); guard++; end
      do begin
         if (wave_o) hi++;
         cyc(0, 0, 8'h00);
         per++;
      end while (!tick_o && per < 1000);
      check(per == exp_per, {req, " period"}, per, exp_per);
      check(hi == exp_hi, {req, " high time"}, hi, exp_hi);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R7: no writes after reset -> wave and tick stay 0
      for (int i = 0; i < 10; i++) cyc(0, 0, 8'h00);

      // Table walk: R2, R3, R4, R5, R6 against the reference accumulator
      for (int v = 0; v < NV; v++) begin
         int tk = 0;
         int mk = 0;
         put_word(VEC_CW[v]);
         for (int c = 0; c < VEC_N[v]; c++) begin
            cyc(0, 0, 8'h00);
            tk += tick_o;
            mk += m_tick;
         end
         check(tk == mk, "R4 tick count", tk, mk);
      end

      // R6: zero word freezes the wave and gives no ticks
      begin
         logic lvl;
         int tk = 0;
         lvl = wave_o;
         for (int c = 0; c < 30; c++) begin
            cyc(0, 0, 8'h00);
            tk += tick_o;
         end
         check(wave_o == lvl, "R6 frozen wave", wave_o, lvl);
         check(tk == 0, "R6 no ticks", tk, 0);
      end

      // R1: timing of the high byte write. Phase is 0 after reset.
      do_reset();
      cyc(1'b1, 1'b0, 8'h80);   // word becomes 0x8000, phase still 0
      check(wave_o == 1'b0, "R1 not yet applied", wave_o, 0);
      cyc(0, 0, 8'h00);         // phase 0x8000
      check(wave_o == 1'b1, "R1 applied next edge", wave_o, 1);
      check(tick_o == 1'b1, "R5 first tick", tick_o, 1);
      // R1: low byte write keeps high byte (0x8000 -> 0x8000), wave toggles
      cyc(0, 1'b1, 8'h00);
      check(wave_o == 1'b0, "R1 hi byte kept", wave_o, 0);

      // R4 and R8: step 0x1000 gives a 16-cycle period, 8 high
      do_reset();
      put_word(16'h1000);
      measure("R8 0x1000", 16, 8);
      // R3: 0xF000 acts as 0x1000
      put_word(16'hF000);
      measure("R3 0xF000", 16, 8);
      // R3: 0x8000 toggles every cycle
      put_word(16'h8000);
      measure("R3 0x8000", 2, 1);
      // R8: step 0x0400 gives 64 cycles, 32 high
      put_word(16'h0400);
      measure("R8 0x0400", 64, 32);

      // R9: word change keeps phase
      do_reset();
      put_word(16'h4000);        // phase 0x4000 after lo write edge
      cyc(0, 0, 8'h00);          // phase 0x8000
      check(wave_o == 1'b1, "R9 phase at half", wave_o, 1);
      cyc(1'b1, 1'b0, 8'h01);    // phase 0xC000, word now 0x0100
      cyc(0, 0, 8'h00);          // phase 0xC100
      check(wave_o == 1'b1, "R9 phase kept after change", wave_o, 1);
      for (int c = 0; c < 20; c++) cyc(0, 0, 8'h00);
      check(wave_o == 1'b1, "R9 slow step continues", wave_o, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule